// File: doc/BRIEF.md
# Cache Line Refill Sequencer

This block fetches one whole cache line from a system bus whose memory requests are shorter than a line. A refill request gives a line address. The sequencer clears the offset bits of that address. It then places two read requests on the bus, one for each half of the line. It collects the data beats that come back and assembles them into a full-width line image. When the last beat is in, it presents the complete line for a single cycle.

With the default parameters the line is 128 bytes, each bus request covers 64 bytes, and each returned beat carries 32 bytes. One line therefore needs two requests and four beats. Beats are taken in arrival order. They may start as soon as the first request has been accepted, even while the second request is still waiting for the bus. Only one refill is in flight at a time.

Top module: `line_refill_seq`

## Requirements
- R1: On acceptance, the refill address is aligned down to a line boundary: its low log2(LINE_BYTES) bits are cleared. That aligned value is driven on `line_addr` for the rest of the refill.
- R2: The block issues LINE_BYTES/REQ_BYTES bus requests per refill. Their addresses are base, base+REQ_BYTES, and so on, in that order.
- R3: While `bus_req_valid` is high and `bus_req_ready` is low, the request stays valid and `bus_req_addr` does not change.
- R4: The k-th beat received during a refill (k counted from 0) fills bytes k*BEAT_BYTES up to (k+1)*BEAT_BYTES-1 of `line_data`. Beat 0 sits in the least significant bits. Beats are accepted both before and after the last request has been issued.
- R5: `line_valid` is high for exactly one cycle, the cycle after the final beat is captured. The block is idle again in the next cycle.
- R6: `fill_ready` is high only while idle. A `fill_valid` that arrives while a refill is in progress has no effect.
- R7: A beat that arrives (`rsp_valid`) while the block is idle is ignored. It does not count toward the next refill.
- R8: A synchronous reset during a refill returns the block to idle and drops the partial line. The next refill again needs all of its beats.
- R9: After reset, `fill_ready` is 1 and both `bus_req_valid` and `line_valid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| fill_valid | input | 1 | Refill request present |
| fill_ready | output | 1 | Sequencer idle and able to take a refill |
| fill_addr | input | ADDR_W | Byte address inside the line to refill |
| bus_req_valid | output | 1 | Bus read request present |
| bus_req_ready | input | 1 | Bus takes the request this cycle |
| bus_req_addr | output | ADDR_W | Byte address of the bus request |
| rsp_valid | input | 1 | Data beat present |
| rsp_data | input | BEAT_BYTES*8 | Data beat |
| line_valid | output | 1 | One-cycle strobe: assembled line available |
| line_addr | output | ADDR_W | Aligned base address of the refill |
| line_data | output | LINE_BYTES*8 | Assembled line |

## Verification
The bench builds the sequencer with ADDR_W=16, LINE_BYTES=16, REQ_BYTES=8 and BEAT_BYTES=4. These values keep the same geometry as the defaults: two requests and four beats per line. Because each beat is 32 bits and each line is 128 bits, every beat position can be given a distinct recognisable value and compared in full. The small address space lets unaligned addresses, request stalls, beats arriving between the two requests, stray beats while idle and a reset in mid-refill all be reached within a few hundred cycles.

// File: rtl/line_refill_seq.sv
module line_refill_seq #(
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 128,
  parameter int REQ_BYTES  = 64,
  parameter int BEAT_BYTES = 32
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    fill_valid,
  output logic                    fill_ready,
  input  logic [ADDR_W-1:0]       fill_addr,
  output logic                    bus_req_valid,
  input  logic                    bus_req_ready,
  output logic [ADDR_W-1:0]       bus_req_addr,
  input  logic                    rsp_valid,
  input  logic [BEAT_BYTES*8-1:0] rsp_data,
  output logic                    line_valid,
  output logic [ADDR_W-1:0]       line_addr,
  output logic [LINE_BYTES*8-1:0] line_data
);

  localparam int BEAT_W   = BEAT_BYTES * 8;
  localparam int NREQ     = LINE_BYTES / REQ_BYTES;
  localparam int NBEAT    = LINE_BYTES / BEAT_BYTES;
  localparam int LINE_OFS = $clog2(LINE_BYTES);
  localparam int REQ_OFS  = $clog2(REQ_BYTES);
  localparam int REQ_CW   = (NREQ > 1) ? $clog2(NREQ) : 1;
  localparam int BEAT_CW  = (NBEAT > 1) ? $clog2(NBEAT) : 1;
  localparam logic [ADDR_W-1:0] ALIGN_MASK = {ADDR_W{1'b1}} << LINE_OFS;

  typedef enum logic [1:0] {S_IDLE, S_ISSUE, S_COLLECT, S_DONE} phase_t;

  phase_t              phase;
  logic [ADDR_W-1:0]   base;
  logic [REQ_CW-1:0]   req_idx;
  logic [BEAT_CW-1:0]  beat_idx;

  wire accept    = fill_valid && fill_ready;
  wire req_fire  = bus_req_valid && bus_req_ready;
  wire busy      = (phase == S_ISSUE) || (phase == S_COLLECT);
  wire beat_take = busy && rsp_valid;
  wire last_req  = (req_idx == REQ_CW'(NREQ - 1));
  wire last_beat = (beat_idx == BEAT_CW'(NBEAT - 1));

  assign fill_ready    = (phase == S_IDLE);
  assign bus_req_valid = (phase == S_ISSUE);
  assign bus_req_addr  = base | (ADDR_W'(req_idx) << REQ_OFS);
  assign line_valid    = (phase == S_DONE);
  assign line_addr     = base;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase    <= S_IDLE;
      base     <= '0;
      req_idx  <= '0;
      beat_idx <= '0;
    end else begin
      case (phase)
        S_IDLE: if (accept) begin
          phase    <= S_ISSUE;
          base     <= fill_addr & ALIGN_MASK;
          req_idx  <= '0;
          beat_idx <= '0;
        end
        S_ISSUE: if (req_fire) begin
          if (last_req) begin
            phase   <= S_COLLECT;
            req_idx <= '0;
          end else begin
            req_idx <= req_idx + 1'b1;
          end
        end
        S_DONE:  phase <= S_IDLE;
        default: ;
      endcase
      if (beat_take) begin
        beat_idx <= beat_idx + 1'b1;
        if (last_beat) phase <= S_DONE;
      end
    end
  end

  for (genvar g = 0; g < NBEAT; g++) begin : g_slot
    logic [BEAT_W-1:0] slot;
    always_ff @(posedge clk) begin
      if (beat_take && beat_idx == BEAT_CW'(g)) slot <= rsp_data;
    end
    assign line_data[g*BEAT_W +: BEAT_W] = slot;
  end

endmodule

// File: rtl/line_refill_seq_chk.sv
module line_refill_seq_chk #(
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 128,
  parameter int REQ_BYTES  = 64
) (
  input logic              clk,
  input logic              rst,
  input logic              fill_valid,
  input logic              fill_ready,
  input logic              bus_req_valid,
  input logic              bus_req_ready,
  input logic [ADDR_W-1:0] bus_req_addr,
  input logic              line_valid,
  input logic [ADDR_W-1:0] line_addr
);
  localparam int LINE_OFS = $clog2(LINE_BYTES);
  localparam int REQ_OFS  = $clog2(REQ_BYTES);

  a_r5_single_pulse: assert property (@(posedge clk) disable iff (rst)
    line_valid |=> !line_valid);

  a_r3_req_hold: assert property (@(posedge clk) disable iff (rst)
    (bus_req_valid && !bus_req_ready) |=> (bus_req_valid && $stable(bus_req_addr)));

  a_r6_busy_after_accept: assert property (@(posedge clk) disable iff (rst)
    (fill_valid && fill_ready) |=> !fill_ready);

  a_r6_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    fill_ready |-> (!bus_req_valid && !line_valid));

  a_r2_req_in_line: assert property (@(posedge clk) disable iff (rst)
    bus_req_valid |-> (bus_req_addr[REQ_OFS-1:0] == '0 &&
                       bus_req_addr[ADDR_W-1:LINE_OFS] == line_addr[ADDR_W-1:LINE_OFS]));

  a_r1_base_aligned: assert property (@(posedge clk) disable iff (rst)
    line_valid |-> (line_addr[LINE_OFS-1:0] == '0));

  a_r8_reset_idle: assert property (@(posedge clk)
    rst |=> (fill_ready && !bus_req_valid && !line_valid));
endmodule

bind line_refill_seq line_refill_seq_chk #(
  .ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES), .REQ_BYTES(REQ_BYTES)
) u_chk (
  .clk(clk), .rst(rst), .fill_valid(fill_valid), .fill_ready(fill_ready),
  .bus_req_valid(bus_req_valid), .bus_req_ready(bus_req_ready),
  .bus_req_addr(bus_req_addr), .line_valid(line_valid), .line_addr(line_addr)
);

// File: tb/line_refill_seq_tb.sv
`timescale 1ns/1ps
module line_refill_seq_tb;
  localparam int AW = 16, LB = 16, RB = 8, BB = 4;
  localparam int LW = LB * 8, BW = BB * 8;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst = 1'b1;
  logic fill_valid = 1'b0, bus_req_ready = 1'b0, rsp_valid = 1'b0;
  logic [AW-1:0] fill_addr = '0;
  logic [BW-1:0] rsp_data = '0;
  logic fill_ready, bus_req_valid, line_valid;
  logic [AW-1:0] bus_req_addr, line_addr;
  logic [LW-1:0] line_data;

  line_refill_seq #(.ADDR_W(AW), .LINE_BYTES(LB), .REQ_BYTES(RB), .BEAT_BYTES(BB)) u_dut (
    .clk(clk), .rst(rst), .fill_valid(fill_valid), .fill_ready(fill_ready),
    .fill_addr(fill_addr), .bus_req_valid(bus_req_valid), .bus_req_ready(bus_req_ready),
    .bus_req_addr(bus_req_addr), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .line_valid(line_valid), .line_addr(line_addr), .line_data(line_data));

  int total = 0, bad = 0;
  typedef struct packed { logic [AW-1:0] a; logic [LW-1:0] d; } line_t;
  line_t expq[$];
  logic prev_lv = 1'b0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [LW-1:0] act, input logic [LW-1:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!rst) begin
      if (line_valid) begin
        if (prev_lv) chk(1'b0, "R5", "strobe longer than one cycle", 1, 0);
        if (expq.size() == 0) chk(1'b0, "R5", "unexpected line", line_data, 0);
        else begin
          line_t e;
          e = expq.pop_front();
          chk(line_data == e.d, "R4", "line data", line_data, e.d);
          chk(line_addr == e.a, "R1", "line base", LW'(line_addr), LW'(e.a));
        end
      end
      if (bus_req_valid) chk(!fill_ready, "R6", "ready while busy", LW'(fill_ready), 0);
      prev_lv = line_valid;
    end else prev_lv = 1'b0;
  end

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic start(input logic [AW-1:0] a);
    while (!fill_ready) tick();
    fill_valid = 1'b1; fill_addr = a;
    tick();
    fill_valid = 1'b0;
  endtask

  task automatic issue(input logic [AW-1:0] ea, input int stall);
    int n = 0;
    while (!bus_req_valid && n < 50) begin tick(); n++; end
    for (int i = 0; i < stall; i++) begin
      chk(bus_req_valid && bus_req_addr == ea, "R3", "held request", LW'(bus_req_addr), LW'(ea));
      tick();
    end
    chk(bus_req_valid && bus_req_addr == ea, "R2", "request address", LW'(bus_req_addr), LW'(ea));
    bus_req_ready = 1'b1;
    tick();
    bus_req_ready = 1'b0;
  endtask

  task automatic beat(input logic [BW-1:0] d, input int gap);
    repeat (gap) tick();
    rsp_valid = 1'b1; rsp_data = d;
    tick();
    rsp_valid = 1'b0;
  endtask

  task automatic refill(input logic [AW-1:0] a, input logic [LW-1:0] d,
                        input bit interleave, input int stall);
    logic [AW-1:0] b;
    line_t e;
    b = a & ~AW'(LB - 1);
    e.a = b; e.d = d;
    expq.push_back(e);
    start(a);
    issue(b, stall);
    if (interleave) begin
      beat(d[0*BW +: BW], 0);
      beat(d[1*BW +: BW], 1);
      issue(b + AW'(RB), 0);
    end else begin
      issue(b + AW'(RB), stall);
      beat(d[0*BW +: BW], 2);
      beat(d[1*BW +: BW], 0);
    end
    beat(d[2*BW +: BW], 0);
    beat(d[3*BW +: BW], 1);
    tick();
    tick();
  endtask

  initial begin
    #(200000 * 20);
    chk(1'b0, "WDOG", "watchdog expired", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    tick(); tick();
    rst = 1'b0;
    // R9 reset state
    chk(fill_ready && !bus_req_valid && !line_valid, "R9", "reset outputs",
        LW'({fill_ready, bus_req_valid, line_valid}), LW'(3'b100));

    // R2 R4 R5 aligned address, both requests then beats
    refill(16'h0100, 128'h33333333_22222222_11111111_00000000, 1'b0, 0);
    // R1 unaligned address, R4 beats between requests
    refill(16'h1237, 128'hdeadbeef_cafef00d_01234567_89abcdef, 1'b1, 0);
    // R3 stalled requests
    refill(16'h4ff9, 128'ha5a5a5a5_5a5a5a5a_0f0f0f0f_f0f0f0f0, 1'b0, 3);
    // R5 back to back, idle reached between refills
    refill(16'h0010, 128'h44444444_55555555_66666666_77777777, 1'b1, 1);
    refill(16'h0020, 128'h88888888_99999999_aaaaaaaa_bbbbbbbb, 1'b0, 0);

    // R7 stray beats while idle
    beat(32'hbad0bad0, 0);
    beat(32'hbad1bad1, 1);
    chk(!line_valid && fill_ready, "R7", "idle after stray beats",
        LW'({line_valid, fill_ready}), LW'(2'b01));
    refill(16'h7770, 128'h0c0c0c0c_0b0b0b0b_0a0a0a0a_09090909, 1'b0, 0);

    // R6 refill request held high during a busy refill
    begin
      line_t e;
      e.a = 16'h2200; e.d = 128'h10101010_20202020_30303030_40404040;
      expq.push_back(e);
      start(16'h2200);
      fill_valid = 1'b1; fill_addr = 16'h9900;
      issue(16'h2200, 1);
      issue(16'h2208, 0);
      fill_valid = 1'b0;
      beat(e.d[0*BW +: BW], 0);
      beat(e.d[1*BW +: BW], 0);
      beat(e.d[2*BW +: BW], 0);
      beat(e.d[3*BW +: BW], 0);
      repeat (4) tick();
      chk(!bus_req_valid && fill_ready, "R6", "no refill from busy-time request",
          LW'({bus_req_valid, fill_ready}), LW'(2'b01));
    end

    // R8 reset during a refill
    start(16'h3330);
    issue(16'h3330, 0);
    beat(32'hffffffff, 0);
    rst = 1'b1;
    tick();
    rst = 1'b0;
    chk(fill_ready && !bus_req_valid && !line_valid, "R8", "idle after mid reset",
        LW'({fill_ready, bus_req_valid, line_valid}), LW'(3'b100));
    refill(16'h3330, 128'h13579bdf_2468ace0_fedcba98_76543210, 1'b1, 0);

    repeat (3) tick();
    chk(expq.size() == 0, "R5", "lines still pending", LW'(expq.size()), 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule